// File: doc/BRIEF.md
# Signed-Scalar Big Integer Multiply-Accumulate Sequencer

The block holds an unsigned big integer as a small array of 64-bit limbs, with limb 0 the least significant. It multiplies that integer by a signed 64-bit scalar and adds a signed 64-bit carry-in. It works one limb per clock, from the lowest index upward. Each step forms limb times scalar plus the running carry as a 128-bit two's complement value. The low word goes back into the same limb. The high word becomes the carry for the next limb. After the last limb, the carry register holds the signed top word of the result, and it is presented as the carry-out.

Limbs enter through a valid/ready load port. `lw_ready` is high whenever no run is active, and a word transfers on each clock edge where `lw_valid` and `lw_ready` are both high. While a run is active, `lw_ready` is low and the port applies back-pressure. The source may hold its word until the run ends, or it may withdraw it. Results are read back through a combinational read port. A run is launched with a plain `start` pulse. A plain `done` pulse reports the end of the run.

Top module: `bmcs_top`

## Requirements
- R1: For each processed limb i, the value limb[i] (unsigned) times scalar (two's complement) plus carry (two's complement) is formed over 128 bits. Bits 63:0 replace limb[i] and bits 127:64 become the new carry.
- R2: After a start is accepted on clock edge E0, limb i is written on edge E(i+1), in ascending index order. `busy` is high from E0 until the last write.
- R3: `done` is high for exactly the one cycle after the last limb write, with `busy` low. In that cycle `carry_out` equals the final carry.
- R4: A start with `vlen` = 0 raises `done` in the cycle after acceptance, with `carry_out` equal to `carry_in`, and leaves every limb unchanged.
- R5: A `vlen` larger than the number of limbs NLIMB (default 4) is treated as NLIMB.
- R6: A `start` raised while `busy` is high is ignored. The active run and its operands are unaffected, and no extra `done` follows.
- R7: `lw_ready` is the inverse of `busy`. When `lw_valid` and `lw_ready` are both high at an edge, `lw_data` is stored at `lw_addr` and can be read on `rd_data` from the next cycle. A load offered while busy stores nothing.
- R8: `carry_out` holds its value from the end of a run until the next accepted start.
- R9: A start presented during the `done` cycle is accepted, and the next run begins at once.
- R10: A load and a start accepted on the same edge are ordered load first, so the run sees the newly loaded limb.
- R11: After reset, `busy` and `done` are low, `carry_out` is zero, `lw_ready` is high and every limb reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a run (accepted when not busy) |
| vlen | input | 3 | Number of limbs to process (clamped to NLIMB) |
| scalar | input | 64 | Signed multiplier, captured at start |
| carry_in | input | 64 | Signed initial addend, captured at start |
| busy | output | 1 | A run is stepping through limbs |
| done | output | 1 | One-cycle end-of-run pulse |
| carry_out | output | 64 | Final signed carry word |
| lw_valid | input | 1 | Load word offered |
| lw_ready | output | 1 | Load port can accept a word |
| lw_addr | input | 2 | Limb index to load |
| lw_data | input | 64 | Limb value to load |
| rd_addr | input | 2 | Limb index to read back |
| rd_data | output | 64 | Limb value at rd_addr |

## Verification
Two functions can fall in the same cycle, and the bench provokes both. A limb load and a run start can be accepted on the same edge. A new start can also coincide with the `done` pulse of the previous run. In the first case, the bench offers the load and raises start in one cycle. It then expects the scoreboard result computed from the newly loaded limb, which tests that the write lands before the sequencer reads limb 0. In the second case, the bench raises start in the `done` cycle. The monitor must see the earlier run's limbs intact during that cycle, and the following run must then produce its own correct result.

// File: rtl/bmcs_pkg.sv
package bmcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/bmcs_mac.sv
// Mixed-sign multiply-add: unsigned limb times signed scalar plus signed carry.
module bmcs_mac #(
  parameter int W = 64
) (
  input  logic [W-1:0] limb,
  input  logic [W-1:0] scalar,
  input  logic [W-1:0] carry,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  localparam int XW = 2 * W + 1;

  logic signed [XW-1:0] a_ext;
  logic signed [XW-1:0] b_ext;
  logic signed [XW-1:0] c_ext;
  logic signed [XW-1:0] sum;

  always_comb begin
    a_ext = {{(W + 1){1'b0}}, limb};
    b_ext = {{(W + 1){scalar[W-1]}}, scalar};
    c_ext = {{(W + 1){carry[W-1]}}, carry};
    sum   = a_ext * b_ext + c_ext;
    lo    = sum[W-1:0];
    hi    = sum[2*W-1:W];
  end
endmodule

// File: rtl/bmcs_limb_file.sv
// Limb storage: one write port, two combinational read ports.
module bmcs_limb_file #(
  parameter int W  = 64,
  parameter int N  = 4,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] mem [N];

  for (genvar g = 0; g < N; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[g] <= '0;
      end else if (we && (32'(waddr) == g)) begin
        mem[g] <= wdata;
      end
    end
  end

  always_comb begin
    rdata_a = '0;
    rdata_b = '0;
    for (int i = 0; i < N; i++) begin
      if (32'(raddr_a) == i) rdata_a = mem[i];
      if (32'(raddr_b) == i) rdata_b = mem[i];
    end
  end
endmodule

// File: rtl/bmcs_seq.sv
// Run controller: accepts start, walks the limb index, pulses done.
module bmcs_seq
  import bmcs_pkg::*;
#(
  parameter int N  = 4,
  parameter int LW = 3,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] vlen,
  output logic          accept,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] idx
);
  seq_state_e    state_q;
  logic [AW-1:0] idx_q;
  logic [AW-1:0] last_q;
  logic [LW-1:0] len_c;

  always_comb begin
    len_c  = (vlen > LW'(N)) ? LW'(N) : vlen;
    busy   = (state_q == ST_RUN);
    done   = (state_q == ST_FIN);
    accept = start && !busy;
    idx    = idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (idx_q == last_q) begin
            state_q <= ST_FIN;
          end else begin
            idx_q <= idx_q + AW'(1);
          end
        end
        default: begin
          if (start) begin
            idx_q <= '0;
            if (len_c == '0) begin
              state_q <= ST_FIN;
              last_q  <= '0;
            end else begin
              state_q <= ST_RUN;
              last_q  <= AW'(len_c - LW'(1));
            end
          end else begin
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx_q != last_q) |=> (busy && idx_q == $past(idx_q) + AW'(1)));

  // R3
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R4
  empty_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && vlen == '0) |=> (done && !busy));

  // R6
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (last_q == $past(last_q)));
endmodule

// File: rtl/bmcs_top.sv
// Big integer times signed scalar plus signed carry, one limb per cycle.
module bmcs_top #(
  parameter int W     = 64,
  parameter int NLIMB = 4,
  parameter int LW    = $clog2(NLIMB + 1),
  parameter int AW    = (NLIMB > 1) ? $clog2(NLIMB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] vlen,
  input  logic [W-1:0]  scalar,
  input  logic [W-1:0]  carry_in,
  output logic          busy,
  output logic          done,
  output logic [W-1:0]  carry_out,
  input  logic          lw_valid,
  output logic          lw_ready,
  input  logic [AW-1:0] lw_addr,
  input  logic [W-1:0]  lw_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic          accept;
  logic [AW-1:0] idx;
  logic [W-1:0]  scalar_q;
  logic [W-1:0]  carry_q;
  logic [W-1:0]  limb_cur;
  logic [W-1:0]  mac_lo;
  logic [W-1:0]  mac_hi;
  logic          file_we;
  logic [AW-1:0] file_waddr;
  logic [W-1:0]  file_wdata;

  bmcs_seq #(.N(NLIMB), .LW(LW), .AW(AW)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .vlen   (vlen),
    .accept (accept),
    .busy   (busy),
    .done   (done),
    .idx    (idx)
  );

  bmcs_mac #(.W(W)) u_mac (
    .limb   (limb_cur),
    .scalar (scalar_q),
    .carry  (carry_q),
    .lo     (mac_lo),
    .hi     (mac_hi)
  );

  always_comb begin
    lw_ready   = !busy;
    file_we    = busy || (lw_valid && lw_ready);
    file_waddr = busy ? idx : lw_addr;
    file_wdata = busy ? mac_lo : lw_data;
    carry_out  = carry_q;
  end

  bmcs_limb_file #(.W(W), .N(NLIMB), .AW(AW)) u_file (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (file_we),
    .waddr   (file_waddr),
    .wdata   (file_wdata),
    .raddr_a (idx),
    .rdata_a (limb_cur),
    .raddr_b (rd_addr),
    .rdata_b (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scalar_q <= '0;
      carry_q  <= '0;
    end else if (accept) begin
      scalar_q <= scalar;
      carry_q  <= carry_in;
    end else if (busy) begin
      carry_q  <= mac_hi;
    end
  end

  // R1
  zero_scalar_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && scalar_q == '0) |-> (mac_lo == carry_q && mac_hi == {W{carry_q[W-1]}}));

  // R8
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(carry_out));

  // R7
  load_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (file_waddr == idx && file_wdata == mac_lo));
endmodule

// File: tb/bmcs_top_test.sv
module bmcs_top_test;
  localparam int N  = 4;
  localparam int TW = 64 * (N + 2);

  typedef struct packed {
    logic [64*N-1:0] limbs;
    logic [63:0]     carry;
    logic [2:0]      vl;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  vlen = '0;
  logic [63:0] scalar = '0;
  logic [63:0] carry_in = '0;
  logic        busy, done, lw_ready;
  logic [63:0] carry_out, rd_data;
  logic        lw_valid = 1'b0;
  logic [1:0]  lw_addr = '0;
  logic [63:0] lw_data = '0;
  logic [1:0]  rd_addr = '0;

  int checks = 0;
  int failures = 0;
  int dones = 0;
  int runs = 0;
  bit finished = 1'b0;
  item_t sb_q[$];
  logic [63:0] mirror [N];
  logic [63:0] last_carry;

  bmcs_top uut (
    .clk(clk), .rst_n(rst_n), .start(start), .vlen(vlen), .scalar(scalar),
    .carry_in(carry_in), .busy(busy), .done(done), .carry_out(carry_out),
    .lw_valid(lw_valid), .lw_ready(lw_ready), .lw_addr(lw_addr),
    .lw_data(lw_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Reference: whole big integer times signed scalar plus signed carry.
  function automatic item_t model_run(input int vl, input logic [63:0] s,
                                      input logic [63:0] c);
    logic signed [TW-1:0] a, b, cc, t;
    item_t it;
    a = '0;
    for (int i = 0; i < vl; i++) a[64*i +: 64] = mirror[i];
    b  = {{(TW-64){s[63]}}, s};
    cc = {{(TW-64){c[63]}}, c};
    t  = a * b + cc;
    it.limbs = '0;
    for (int i = 0; i < vl; i++) it.limbs[64*i +: 64] = t[64*i +: 64];
    it.carry = t[64*vl +: 64];
    it.vl = 3'(vl);
    return it;
  endfunction

  // Driver: called at a negedge, returns at the negedge after acceptance.
  task automatic start_run(input int vreq, input logic [63:0] s,
                           input logic [63:0] c);
    int vl;
    item_t it;
    vl = (vreq > N) ? N : vreq;
    start = 1'b1; vlen = 3'(vreq); scalar = s; carry_in = c;
    it = model_run(vl, s, c);
    sb_q.push_back(it);
    runs++;
    for (int i = 0; i < vl; i++) mirror[i] = it.limbs[64*i +: 64];
    last_carry = it.carry;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic load(input int a, input logic [63:0] d);
    lw_valid = 1'b1; lw_addr = 2'(a); lw_data = d;
    chk(lw_ready == 1'b1, "R7 ready when idle", 64'(lw_ready), 64'd1);
    mirror[a] = d;
    @(negedge clk);
    lw_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy || done) @(negedge clk);
  endtask

  task automatic check_mirror(input string req);
    for (int i = 0; i < N; i++) begin
      rd_addr = 2'(i);
      #1;
      chk(rd_data == mirror[i], req, rd_data, mirror[i]);
    end
  endtask

  // Monitor: pops the scoreboard on every done pulse.
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        dones++;
        if (sb_q.size() == 0) begin
          chk(1'b0, "R6 unexpected done", 64'd1, 64'd0);
        end else begin
          it = sb_q.pop_front();
          chk(carry_out == it.carry, "R3 carry_out at done", carry_out, it.carry);
          for (int i = 0; i < int'(it.vl); i++) begin
            rd_addr = 2'(i);
            #1;
            chk(rd_data == it.limbs[64*i +: 64], "R1 limb result", rd_data,
                it.limbs[64*i +: 64]);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    report();
  end

  initial begin
    for (int i = 0; i < N; i++) mirror[i] = '0;
    last_carry = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(busy == 1'b0, "R11 busy", 64'(busy), 64'd0);
    chk(done == 1'b0, "R11 done", 64'(done), 64'd0);
    chk(carry_out == '0, "R11 carry_out", carry_out, 64'd0);
    chk(lw_ready == 1'b1, "R11 lw_ready", 64'(lw_ready), 64'd1);
    check_mirror("R11 limbs zero");

    // Reference case with timing (R1, R2, R3)
    load(0, 64'h1357_0000_9BDF_0000);
    load(1, 64'h9ABC_0000_DEF0_0000);
    load(2, 64'h1234_0000_5678_0000);
    start_run(3, 64'hFFFF_FFFF_FFFE_FFFF, 64'hFFFF_FFFF_FFFF_0124);
    for (int k = 0; k < 3; k++) begin
      chk(busy == 1'b1 && done == 1'b0, "R2 busy during steps", 64'(busy), 64'd1);
      @(negedge clk);
    end
    chk(done == 1'b1 && busy == 1'b0, "R3 done after last write", 64'(done), 64'd1);
    chk(carry_out == 64'hFFFF_FFFF_FFFF_EDCB, "R3 reference carry", carry_out,
        64'hFFFF_FFFF_FFFF_EDCB);
    @(negedge clk);
    chk(done == 1'b0, "R3 single pulse", 64'(done), 64'd0);
    rd_addr = 2'd0; #1;
    chk(rd_data == 64'hECA8_6420_6420_0124, "R1 ref limb0", rd_data, 64'hECA8_6420_6420_0124);
    rd_addr = 2'd1; #1;
    chk(rd_data == 64'h6543_210F_210F_ECA8, "R1 ref limb1", rd_data, 64'h6543_210F_210F_ECA8);
    rd_addr = 2'd2; #1;
    chk(rd_data == 64'hEDCB_A987_A987_6543, "R1 ref limb2", rd_data, 64'hEDCB_A987_A987_6543);
    @(negedge clk);

    // R8 carry held while idle
    repeat (3) @(negedge clk);
    chk(carry_out == last_carry, "R8 carry held", carry_out, last_carry);

    // R4 empty run
    start_run(0, 64'h1234, 64'h8000_0000_0000_0005);
    chk(done == 1'b1 && busy == 1'b0, "R4 immediate done", 64'(done), 64'd1);
    chk(carry_out == 64'h8000_0000_0000_0005, "R4 carry passthrough", carry_out,
        64'h8000_0000_0000_0005);
    wait_idle();
    check_mirror("R4 limbs untouched");

    // R5 clamp, extreme operands
    load(0, 64'hFFFF_FFFF_FFFF_FFFF);
    load(1, 64'hFFFF_FFFF_FFFF_FFFF);
    load(2, 64'h0000_0000_0000_0001);
    load(3, 64'h8000_0000_0000_0000);
    start_run(5, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF);
    wait_idle();
    check_mirror("R5 clamped run");

    // R6 start while busy ignored, R7 load blocked while busy
    start_run(4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0003);
    start = 1'b1; vlen = 3'd1; scalar = 64'h5555; carry_in = 64'h9999;
    lw_valid = 1'b1; lw_addr = 2'd3; lw_data = 64'hDEAD_BEEF_DEAD_BEEF;
    #1;
    chk(lw_ready == 1'b0, "R7 not ready while busy", 64'(lw_ready), 64'd0);
    @(negedge clk);
    start = 1'b0; lw_valid = 1'b0;
    wait_idle();
    check_mirror("R6 R7 run unaffected");
    chk(dones == runs, "R6 no extra done", 64'(dones), 64'(runs));

    // R9 back-to-back start in the done cycle
    start_run(2, 64'h0000_0000_0001_0000, 64'hFFFF_FFFF_FFFF_FFFF);
    while (!done) @(negedge clk);
    start_run(3, 64'h0000_0000_0000_0007, 64'h0000_0000_0000_0011);
    chk(busy == 1'b1, "R9 next run started", 64'(busy), 64'd1);
    wait_idle();
    check_mirror("R9 back-to-back result");

    // R10 load and start on the same edge
    lw_valid = 1'b1; lw_addr = 2'd0; lw_data = 64'h0F0F_0F0F_0F0F_0F0F;
    mirror[0] = 64'h0F0F_0F0F_0F0F_0F0F;
    start_run(2, 64'hFFFF_FFFF_FFFF_FFFD, 64'h0000_0000_0000_0100);
    lw_valid = 1'b0;
    wait_idle();
    check_mirror("R10 load before run");

    // R1 zero scalar: limbs become carry then sign fill
    start_run(3, 64'h0, 64'hFFFF_FFFF_FFFF_FF00);
    wait_idle();
    check_mirror("R1 zero scalar");

    @(negedge clk);
    chk(sb_q.size() == 0, "R3 all runs completed", 64'(sb_q.size()), 64'd0);
    chk(dones == runs, "R3 done count", 64'(dones), 64'(runs));
    report();
  end
endmodule